// File: doc/BRIEF.md
# Transactional Store Buffer with Commit Drain

This block holds the speculative stores of one running transaction so that memory only ever contains committed values. Every store the processor issues lands in a small associative buffer of address and data pairs instead of memory. A load first searches that buffer, so the transaction sees its own earlier stores, and falls back to memory when the address is not buffered.

Ending the transaction takes one of two paths. A commit copies the buffered pairs into memory through a write port, one pair per cycle in the order their slots were first taken, and holds the processor off while doing so. An abort throws the buffer away in a single cycle and memory is never touched. When a store would need a slot beyond the buffer's capacity, the block aborts the transaction by itself and flags the overflow. After every commit or abort the next request opens a fresh transaction with an empty buffer.

Top module: `txn_wbuf`

## Requirements
- R1: After reset `busy`, `done`, `aborted`, `overflow`, `rsp_valid` and `mem_we` are 0, `req_ready` is 1 and the buffer is empty, so a load returns the memory value.
- R2: A store (req_op 2'b01) never writes memory by itself; `mem_we` is 1 only while a commit drain is in progress.
- R3: A load (req_op 2'b00) accepted at a clock edge raises `rsp_valid` for the following cycle with `rsp_data` equal to the buffered data if the address is buffered, otherwise the value `mem_rdata` had for `mem_raddr` (which follows `req_addr`) in the accepting cycle; `rsp_valid` is 0 otherwise.
- R4: A store to an address already buffered replaces that slot's data without using a new slot, so it never causes an overflow.
- R5: A commit (req_op 2'b10) with N > 0 buffered entries keeps `busy` high for exactly N cycles, presents one entry per cycle on the memory write port in slot allocation order, then pulses `done` for one cycle with `busy` low and the buffer empty.
- R6: A commit with an empty buffer writes nothing, never raises `busy`, and pulses `done` in the cycle after acceptance.
- R7: An abort (req_op 2'b11) empties the buffer at the accepting edge, pulses `done` and `aborted` in the next cycle, and writes nothing to memory.
- R8: A store to a new address while all DEPTH (default 8) slots are taken is dropped, empties the buffer, and pulses `done`, `aborted` and `overflow` together in the next cycle.
- R9: While `busy` is high `req_ready` is 0 and any request presented is ignored: it produces no response and leaves no entry in the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_op | input | 2 | 00 load, 01 store, 10 commit, 11 abort |
| req_addr | input | AW | Load or store address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | DW | Load result |
| mem_raddr | output | AW | Memory read address (combinational read assumed) |
| mem_rdata | input | DW | Memory read data for mem_raddr |
| mem_we | output | 1 | Memory write strobe during commit drain |
| mem_waddr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| busy | output | 1 | Commit drain in progress |
| done | output | 1 | One-cycle pulse when a transaction ends |
| aborted | output | 1 | With done: the transaction was discarded |
| overflow | output | 1 | With done: the discard came from buffer overflow |

## Verification
The bench rewrites a buffered address and reads it back, which catches a design that appends a duplicate slot (stale data on load, wrong drain contents, or a premature overflow once eight distinct addresses are held). It fills all eight slots, rewrites one, then adds a ninth address, so an off-by-one capacity check either overflows early or lets a ninth entry through. It presents a store during a drain and later loads that address, exposing a design that accepts requests while busy; it also counts drain cycles and compares every memory write against the expected ordered list, catching skipped, repeated or reordered entries and any write leaking out of a store or an abort.

// File: rtl/txn_wbuf_pkg.sv
// Shared types for the transactional store buffer.
package txn_wbuf_pkg;

    // Processor request codes; the encoding is visible on req_op.
    typedef enum logic [1:0] {
        OP_LOAD   = 2'b00,
        OP_STORE  = 2'b01,
        OP_COMMIT = 2'b10,
        OP_ABORT  = 2'b11
    } op_e;

    // Controller phase.
    typedef enum logic {
        PH_RUN   = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;

endpackage

// File: rtl/wbuf_slots.sv
// Associative slot array for speculative stores.
// Does: holds DEPTH address/data pairs filled in allocation order, answers
// an address lookup, updates a hit slot or appends a new one, empties in
// one cycle, and offers a read port indexed by slot for the drain.
// Assumes: the caller never asserts wr_en for a miss while full.
module wbuf_slots #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr_en,
    input  logic          clear,
    input  logic [IW-1:0] rd_idx,
    output logic          hit,
    output logic [DW-1:0] hit_data,
    output logic          full,
    output logic [CW-1:0] cnt,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [AW-1:0] slot_addr [DEPTH];
    logic [DW-1:0] slot_data [DEPTH];
    logic [DEPTH-1:0] slot_vld;
    logic [DEPTH-1:0] match;
    logic [IW-1:0] hit_idx;
    logic [IW-1:0] tail_idx;

    // Per-slot address comparators.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            assign match[g] = slot_vld[g] && (slot_addr[g] == addr);
        end
    endgenerate

    // Encode the matching slot (at most one matches).
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) hit_idx = IW'(i);
        end
    end

    assign hit      = |match;
    assign hit_data = slot_data[hit_idx];
    assign full     = (cnt == CW'(DEPTH));
    assign tail_idx = cnt[IW-1:0];
    assign rd_addr  = slot_addr[rd_idx];
    assign rd_data  = slot_data[rd_idx];

    // Occupancy: valid bits and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            slot_vld <= '0;
            cnt      <= '0;
        end else if (wr_en && !hit) begin
            slot_vld[tail_idx] <= 1'b1;
            cnt                <= cnt + 1'b1;
        end
    end

    // Payload: overwrite a hit slot or append at the tail.
    always_ff @(posedge clk) begin
        if (wr_en && !clear) begin
            if (hit) begin
                slot_data[hit_idx] <= wdata;
            end else begin
                slot_addr[tail_idx] <= addr;
                slot_data[tail_idx] <= wdata;
            end
        end
    end

endmodule

// File: rtl/wbuf_ctrl.sv
// Transaction controller for the store buffer.
// Does: accepts requests while running, routes stores into the slots,
// turns a store that finds no room into an overflow abort, sequences the
// commit drain one slot per cycle and raises the end-of-transaction pulses.
// Assumes: the slot array reports hit/full/cnt for the current req_addr.
module wbuf_ctrl
    import txn_wbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic          hit,
    input  logic          full,
    input  logic [CW-1:0] cnt,
    output logic          req_ready,
    output logic          load_acc,
    output logic          wr_en,
    output logic          clear,
    output logic [IW-1:0] drain_idx,
    output logic          busy,
    output logic          rsp_valid,
    output logic          done,
    output logic          aborted,
    output logic          overflow
);

    phase_e phase;
    logic   acc;
    logic   is_st;
    logic   is_cm;
    logic   is_ab;
    logic   ovf_now;
    logic   drain_last;
    logic   cm_empty;

    // Decode the accepted request.
    always_comb begin
        acc        = req_valid && (phase == PH_RUN);
        load_acc   = acc && (req_op == OP_LOAD);
        is_st      = acc && (req_op == OP_STORE);
        is_cm      = acc && (req_op == OP_COMMIT);
        is_ab      = acc && (req_op == OP_ABORT);
        ovf_now    = is_st && !hit && full;
        wr_en      = is_st && (hit || !full);
        cm_empty   = is_cm && (cnt == '0);
        drain_last = (phase == PH_DRAIN) && ({1'b0, drain_idx} == CW'(cnt - 1'b1));
        clear      = is_ab || ovf_now || drain_last;
    end

    assign req_ready = (phase == PH_RUN);
    assign busy      = (phase == PH_DRAIN);

    // Phase and drain pointer sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_RUN;
            drain_idx <= '0;
        end else if (phase == PH_RUN) begin
            drain_idx <= '0;
            if (is_cm && !cm_empty) phase <= PH_DRAIN;
        end else if (drain_last) begin
            phase     <= PH_RUN;
            drain_idx <= '0;
        end else begin
            drain_idx <= drain_idx + 1'b1;
        end
    end

    // Registered one-cycle status pulses and the load response strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            done      <= 1'b0;
            aborted   <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            rsp_valid <= load_acc;
            done      <= is_ab || ovf_now || cm_empty || drain_last;
            aborted   <= is_ab || ovf_now;
            overflow  <= ovf_now;
        end
    end

endmodule

// File: rtl/txn_wbuf.sv
// Transactional store buffer, top level.
// Does: keeps one transaction's stores out of memory until commit, serves
// loads from the buffer or memory, drains on commit, discards on abort.
// Assumes: memory reads are combinational on mem_raddr/mem_rdata and the
// memory accepts one write per cycle on mem_we.
module txn_wbuf
    import txn_wbuf_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] mem_raddr,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          done,
    output logic          aborted,
    output logic          overflow
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic          hit;
    logic          full;
    logic [CW-1:0] cnt;
    logic [DW-1:0] hit_data;
    logic          wr_en;
    logic          clear;
    logic          load_acc;
    logic [IW-1:0] drain_idx;

    wbuf_slots #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (req_addr),
        .wdata    (req_wdata),
        .wr_en    (wr_en),
        .clear    (clear),
        .rd_idx   (drain_idx),
        .hit      (hit),
        .hit_data (hit_data),
        .full     (full),
        .cnt      (cnt),
        .rd_addr  (mem_waddr),
        .rd_data  (mem_wdata)
    );

    wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .hit       (hit),
        .full      (full),
        .cnt       (cnt),
        .req_ready (req_ready),
        .load_acc  (load_acc),
        .wr_en     (wr_en),
        .clear     (clear),
        .drain_idx (drain_idx),
        .busy      (busy),
        .rsp_valid (rsp_valid),
        .done      (done),
        .aborted   (aborted),
        .overflow  (overflow)
    );

    assign mem_raddr = req_addr;
    assign mem_we    = busy;

    // Capture the load result: buffered data wins over memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data <= '0;
        end else if (load_acc) begin
            rsp_data <= hit ? hit_data : mem_rdata;
        end
    end

endmodule

// File: rtl/txn_wbuf_chk.sv
// Property checker for txn_wbuf, attached by bind below.
// Does: checks handshake, response and end-of-transaction ordering.
// Assumes: sampled on the rising clock edge, disabled during reset.
module txn_wbuf_chk #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_op,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          mem_we,
    input logic          busy,
    input logic          done,
    input logic          aborted,
    input logic          overflow
);

    AST_WE_ONLY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R2

    AST_LOAD_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'b00) |=> rsp_valid); // R3

    AST_RSP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready && req_op == 2'b00)); // R3

    AST_DRAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && !aborted)); // R5

    AST_ABORT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'b11) |=> (done && aborted && !busy)); // R7

    AST_OVF_IS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (done && aborted)); // R8

    AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready); // R9

endmodule

bind txn_wbuf txn_wbuf_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_we    (mem_we),
    .busy      (busy),
    .done      (done),
    .aborted   (aborted),
    .overflow  (overflow)
);

// File: tb/txn_wbuf_bench.sv
// Scoreboard bench for txn_wbuf: driver tasks queue expected load results
// and memory writes, a monitor compares them as the design produces them.
module txn_wbuf_bench;

    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] mem_raddr;
    logic [DW-1:0] mem_rdata;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;
    logic          busy;
    logic          done;
    logic          aborted;
    logic          overflow;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] mem [256];
    logic [DW-1:0] rsp_q [$];
    logic [AW-1:0] wa_q [$];
    logic [DW-1:0] wd_q [$];
    logic [AW-1:0] mdl_a [$];
    logic [DW-1:0] mdl_d [$];

    always #5 clk = ~clk;

    txn_wbuf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_txn_wbuf (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_raddr(mem_raddr),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .busy(busy), .done(done), .aborted(aborted),
        .overflow(overflow)
    );

    // Memory model: combinational read, clocked write.
    assign mem_rdata = mem[mem_raddr];
    always @(posedge clk) begin
        if (mem_we) mem[mem_waddr] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare load responses and memory writes with the queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                if (rsp_q.size() == 0) chk(0, "R3/R9", "unexpected rsp", int'(rsp_data), 0);
                else begin
                    logic [DW-1:0] e;
                    e = rsp_q.pop_front();
                    chk(rsp_data == e, "R3", "load data", int'(rsp_data), int'(e));
                end
            end
            if (mem_we) begin
                if (wa_q.size() == 0) chk(0, "R2", "unexpected write", int'(mem_waddr), 0);
                else begin
                    logic [AW-1:0] ea;
                    logic [DW-1:0] ed;
                    ea = wa_q.pop_front();
                    ed = wd_q.pop_front();
                    chk(mem_waddr == ea, "R5", "write addr", int'(mem_waddr), int'(ea));
                    chk(mem_wdata == ed, "R5", "write data", int'(mem_wdata), int'(ed));
                end
            end
        end
    end

    // Drive one request for one accepting edge; returns at the next negedge.
    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
        while (busy) @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic int mdl_find(input logic [AW-1:0] a);
        for (int i = 0; i < mdl_a.size(); i++) if (mdl_a[i] == a) return i;
        return -1;
    endfunction

    task automatic do_load(input logic [AW-1:0] a);
        int k;
        k = mdl_find(a);
        rsp_q.push_back((k >= 0) ? mdl_d[k] : mem[a]);
        issue(2'b00, a, '0);
    endtask

    // Store; returns 1 in ovf when the model predicts an overflow abort.
    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            output bit ovf);
        int k;
        k = mdl_find(a);
        ovf = 0;
        if (k >= 0) mdl_d[k] = d;
        else if (mdl_a.size() < DEPTH) begin
            mdl_a.push_back(a);
            mdl_d.push_back(d);
        end else begin
            ovf = 1;
            mdl_a.delete();
            mdl_d.delete();
        end
        issue(2'b01, a, d);
    endtask

    task automatic do_commit(input bit stray);
        int n;
        int cyc;
        n = mdl_a.size();
        for (int i = 0; i < n; i++) begin
            wa_q.push_back(mdl_a[i]);
            wd_q.push_back(mdl_d[i]);
        end
        mdl_a.delete();
        mdl_d.delete();
        issue(2'b10, '0, '0);
        chk(busy == (n > 0), (n > 0) ? "R5" : "R6", "busy after commit", busy, n > 0);
        chk(req_ready == (n == 0), "R9", "ready during drain", req_ready, n == 0);
        cyc = 0;
        if (stray && n > 1) begin
            req_valid = 1'b1; req_op = 2'b01; req_addr = 8'h40; req_wdata = 16'hDEAD;
        end
        while (busy) begin
            @(negedge clk);
            req_valid = 1'b0;
            cyc++;
        end
        chk(cyc == n, (n > 0) ? "R5" : "R6", "drain cycles", cyc, n);
        chk(done && !aborted, (n > 0) ? "R5" : "R6", "done after commit", done, 1);
        chk(wa_q.size() == 0, "R5", "writes left", wa_q.size(), 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit ovf;
        for (int i = 0; i < 256; i++) mem[i] = DW'(16'h1000 + i * 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(!busy && !done && !aborted && !overflow, "R1", "status idle", busy, 0);
        chk(!rsp_valid && !mem_we, "R1", "no rsp/write", rsp_valid, 0);
        chk(req_ready, "R1", "ready", req_ready, 1);
        do_load(8'h10);                                   // R1 empty buffer

        // R2, R3: stores stay out of memory, loads see them
        do_store(8'h10, 16'hAAAA, ovf);
        do_store(8'h20, 16'hBBBB, ovf);
        chk(mem[8'h10] == DW'(16'h1000 + 16'h30), "R2", "mem after store", int'(mem[8'h10]), 16'h1030);
        do_load(8'h10);
        do_load(8'h30);                                   // R3 miss

        // R4: rewrite keeps one slot
        do_store(8'h10, 16'hCCCC, ovf);
        do_load(8'h10);

        // R5, R9: drain with a stray request during busy
        do_commit(1);
        do_load(8'h10);
        do_load(8'h40);                                   // R9 stray not buffered
        chk(mem[8'h40] == DW'(16'h1000 + 16'hC0), "R9", "stray not written", int'(mem[8'h40]), 16'h10C0);

        // R6: empty commit
        do_commit(0);

        // R7: abort discards
        do_store(8'h50, 16'h1111, ovf);
        issue(2'b11, '0, '0);
        mdl_a.delete(); mdl_d.delete();
        chk(done && aborted && !overflow, "R7", "abort pulses", {done, aborted, overflow}, 3'b110);
        do_load(8'h50);
        do_commit(0);                                     // R7 nothing left

        // R4, R8: fill, rewrite, then overflow
        for (int i = 0; i < DEPTH; i++) do_store(AW'(8'h60 + i), DW'(16'h2000 + i), ovf);
        do_store(8'h63, 16'h3333, ovf);
        chk(!done && !overflow && !ovf, "R4", "rewrite when full", overflow, 0);
        do_load(8'h63);
        do_store(8'h68, 16'h4444, ovf);
        chk(ovf && done && aborted && overflow, "R8", "overflow pulses", {done, aborted, overflow}, 3'b111);
        do_load(8'h60);
        do_load(8'h68);
        do_store(8'h70, 16'h5555, ovf);
        do_commit(0);

        // R5: full eight-entry drain in allocation order
        for (int i = DEPTH - 1; i >= 0; i--) do_store(AW'(8'h80 + i), DW'(16'h6000 + i), ovf);
        do_commit(0);
        do_load(8'h80);
        do_load(8'h87);

        repeat (3) @(negedge clk);
        chk(rsp_q.size() == 0, "R3", "responses left", rsp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule